// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block moves 8-bit frames over a transmit line and a receive line, both timed by a transfer clock. Frames go out and come in least significant bit first. A frame transmits and receives at the same time: each falling clock edge puts one bit on `txd`, and each rising edge captures one bit from `rxd`. The transfer clock idles high between frames.

In master mode the block makes the transfer clock itself. A programmable divider produces it from the system clock. The clock can be steered to either of two output pins. In slave mode the clock comes from `sclk_in`. That input passes through a synchronizer before its edges are used, and both clock output pins stay high.

Software reaches the block through a small register port. It has a data register (transmit buffer on write, receive buffer on read), a control register, a divider register and a status register.

- In normal operation, each frame is started by a write to the transmit buffer.
- In continuous receive mode, reading the receive buffer starts the next frame on its own. That frame sends all ones.
- An inversion bit complements data as it is written into the transmit buffer and as it is read from the receive buffer.

Top module: `csio_port`

Register map (`bus_addr`):
- 0: data. A write loads the transmit buffer; a read returns the receive buffer.
- 1: control. Bit 0 is master, bits 2:1 are the clock pin select, bit 3 is continuous receive, bit 4 is inversion.
- 2: clock divider.
- 3: status. Bit 0 is transmit-buffer-empty, bit 1 is receive-complete, bit 2 is overrun, bit 3 is busy.

## Requirements
- R1: A frame is 8 bits long and is shifted LSB first. `txd` changes only on falling transfer-clock edges and `rxd` is sampled on rising edges. The transfer clock is high outside frames, and `txd` is high from reset until the first frame drives it.
- R2: In master mode every half period of the transfer clock lasts exactly divider+1 system clock cycles.
- R3: In master mode, select code 2'b01 (control bits 2:1) drives `sclk_out_a` and code 2'b10 drives `sclk_out_b`. The unselected pin stays high. Codes 2'b00 and 2'b11 leave both pins high while frames still run.
- R4: In slave mode (control bit 0 = 0), both clock output pins stay high whatever the select code. Bits move on the synchronized edges of `sclk_in`.
- R5: Without continuous mode, only a write to the transmit buffer starts a frame. Reading the receive buffer starts nothing.
- R6: With continuous mode (control bit 3), a read of the receive buffer starts a new frame with no transmit write. When the transmit buffer is empty, that frame sends 8'hFF.
- R7: With inversion (control bit 4), a written byte goes out complemented and a received byte reads back complemented.
- R8: Status bit 0 clears on a transmit buffer write. It sets when the buffer moves into the shifter. A second write made during a frame is sent in the next frame, right after the current one.
- R9: Status bit 1 sets when a frame completes and clears when the receive buffer is read.
- R10: A frame that completes while status bit 1 is set raises status bit 2, and its data replaces the buffer contents. A status read clears bit 2.
- R11: After reset the status reads 8'h01, control and divider read 0, and the clock pins and `txd` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| sclk_in | input | 1 | External transfer clock for slave mode |
| sclk_out_a | output | 1 | First transfer clock output pin |
| sclk_out_b | output | 1 | Second transfer clock output pin |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |

## Verification
Two situations are hard to reach from the ports:
- Overrun, together with a queued second transmit byte. The stimulus writes two bytes back to back, so the second waits in the buffer while the first frame shifts. It then lets both frames finish before any receive read, so the second frame lands on an unread buffer.
- The self-started frame of continuous mode, which has no transmit write behind it. The bench reaches it by reading the receive buffer with the mode on, then waits on the selected clock pin for a frame to appear and checks that it carries all ones.

Random frames then mix pin choice, inversion and divider value.

// File: rtl/csio_pkg.sv
package csio_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;
  localparam int NUM_CLK_PINS = 2;

  typedef struct packed {
    logic                    invert;
    logic                    cont_rx;
    logic [NUM_CLK_PINS-1:0] pin_sel;
    logic                    master;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/csio_clkgen.sv
module csio_clkgen #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic             active,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_sclk,
  output logic             sclk_int,
  output logic             fall_p,
  output logic             rise_p
);
  logic [DIV_W-1:0]       cnt_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;
  logic                   tick;
  logic                   ext_now;

  assign ext_now = sync_q[SYNC_STAGES-1];
  assign tick    = master && active && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q     <= '1;
      ext_prev_q <= 1'b1;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_sclk};
      ext_prev_q <= ext_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active || !master) begin
      cnt_q    <= '0;
      sclk_int <= 1'b1;
    end else if (tick) begin
      cnt_q    <= '0;
      sclk_int <= ~sclk_int;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (master) begin
      fall_p = tick && sclk_int;
      rise_p = tick && !sclk_int;
    end else begin
      fall_p = ext_prev_q && !ext_now;
      rise_p = !ext_prev_q && ext_now;
    end
  end

  // R2: the internal clock never toggles before a full count of div+1
  assert_half_period_R2: assert property (@(posedge clk) disable iff (rst)
    (master && active && $past(master && active) && (sclk_int != $past(sclk_int)))
      |-> (cnt_q == '0));
endmodule

// File: rtl/csio_shifter.sv
module csio_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] start_data,
  input  logic         fall_p,
  input  logic         rise_p,
  input  logic         rxd,
  output logic         active,
  output logic         txd,
  output logic         done_p,
  output logic [W-1:0] rx_data
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

  logic [W-1:0]     tx_sh_q;
  logic [W-1:0]     rx_sh_q;
  logic [CNT_W-1:0] bit_q;

  assign rx_data = rx_sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      txd     <= 1'b1;
      done_p  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      bit_q   <= '0;
    end else begin
      done_p <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          tx_sh_q <= start_data;
          bit_q   <= '0;
        end
      end else begin
        if (fall_p) begin
          txd     <= tx_sh_q[0];
          tx_sh_q <= tx_sh_q >> 1;
        end
        if (rise_p) begin
          rx_sh_q <= {rxd, rx_sh_q[W-1:1]};
          if (bit_q == LAST_BIT) begin
            active <= 1'b0;
            done_p <= 1'b1;
            bit_q  <= '0;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  // R1: an edge detector must never report both edges in one cycle
  assert_single_edge_R1: assert property (@(posedge clk) disable iff (rst)
    !(fall_p && rise_p));
  // R1: txd only moves while a frame is running
  assert_txd_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(active) |-> $stable(txd));
endmodule

// File: rtl/csio_pinmux.sv
module csio_pinmux #(
  parameter int NPINS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic [NPINS-1:0] pin_sel,
  input  logic             sclk_int,
  output logic [NPINS-1:0] pins
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam logic [NPINS-1:0] CODE = NPINS'(1) << i;
    always_ff @(posedge clk) begin
      if (rst) begin
        pins[i] <= 1'b1;
      end else begin
        pins[i] <= (master && pin_sel == CODE) ? sclk_int : 1'b1;
      end
    end
  end

  // R3: at most one output pin is ever low
  assert_one_pin_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~pins));
  // R4: with an external clock every pin rests high
  assert_slave_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !master |=> (&pins));
endmodule

// File: rtl/csio_port.sv
module csio_port #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [csio_pkg::ADDR_W-1:0] bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       sclk_in,
  output logic                       sclk_out_a,
  output logic                       sclk_out_b,
  input  logic                       rxd,
  output logic                       txd
);
  import csio_pkg::*;

  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tx_buf_q;
  logic [DATA_W-1:0] rx_buf_q;
  logic              tx_empty_q;
  logic              rx_done_q;
  logic              ovr_q;
  logic              rearm_q;

  logic              sh_active;
  logic              sh_done;
  logic [DATA_W-1:0] sh_rx;
  logic              sclk_int;
  logic              fall_p;
  logic              rise_p;
  logic              start;
  logic [DATA_W-1:0] start_data;
  logic [NUM_CLK_PINS-1:0] pins;

  logic wr_data, wr_ctrl, wr_div, rd_data, rd_stat;
  logic [DATA_W-1:0] inv_mask;

  assign wr_data  = bus_wr && bus_addr == ADDR_DATA;
  assign wr_ctrl  = bus_wr && bus_addr == ADDR_CTRL;
  assign wr_div   = bus_wr && bus_addr == ADDR_DIV;
  assign rd_data  = bus_rd && bus_addr == ADDR_DATA;
  assign rd_stat  = bus_rd && bus_addr == ADDR_STAT;
  assign inv_mask = {DATA_W{ctrl_q.invert}};

  assign start      = !sh_active && (!tx_empty_q || rearm_q);
  assign start_data = tx_empty_q ? {DATA_W{1'b1}} : tx_buf_q;

  csio_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) clkgen_i (
    .clk(clk), .rst(rst), .master(ctrl_q.master), .active(sh_active),
    .div(div_q), .ext_sclk(sclk_in), .sclk_int(sclk_int),
    .fall_p(fall_p), .rise_p(rise_p)
  );

  csio_shifter #(.W(DATA_W)) shifter_i (
    .clk(clk), .rst(rst), .start(start), .start_data(start_data),
    .fall_p(fall_p), .rise_p(rise_p), .rxd(rxd), .active(sh_active),
    .txd(txd), .done_p(sh_done), .rx_data(sh_rx)
  );

  csio_pinmux #(.NPINS(NUM_CLK_PINS)) pinmux_i (
    .clk(clk), .rst(rst), .master(ctrl_q.master), .pin_sel(ctrl_q.pin_sel),
    .sclk_int(sclk_int), .pins(pins)
  );

  assign sclk_out_a = pins[0];
  assign sclk_out_b = pins[1];

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_div)  div_q  <= DIV_W'(bus_wdata);
    end
  end

  // transmit side
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf_q   <= '0;
      tx_empty_q <= 1'b1;
      rearm_q    <= 1'b0;
    end else begin
      if (start && !tx_empty_q) tx_empty_q <= 1'b1;
      if (wr_data) begin
        tx_buf_q   <= bus_wdata ^ inv_mask;
        tx_empty_q <= 1'b0;
      end
      if (start) rearm_q <= 1'b0;
      if (rd_data && ctrl_q.cont_rx) rearm_q <= 1'b1;
    end
  end

  // receive side and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf_q  <= '0;
      rx_done_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (rd_stat) ovr_q <= 1'b0;
      if (sh_done) begin
        rx_buf_q  <= sh_rx;
        rx_done_q <= 1'b1;
        if (rx_done_q && !rd_data) ovr_q <= 1'b1;
      end else if (rd_data) begin
        rx_done_q <= 1'b0;
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_DATA: bus_rdata <= rx_buf_q ^ inv_mask;
        ADDR_CTRL: bus_rdata <= DATA_W'(ctrl_q);
        ADDR_DIV:  bus_rdata <= DATA_W'(div_q);
        default:   bus_rdata <= DATA_W'({sh_active, ovr_q, rx_done_q, tx_empty_q});
      endcase
    end
  end

  // R10: a frame landing on an unread buffer raises overrun
  assert_overrun_R10: assert property (@(posedge clk) disable iff (rst)
    (sh_done && rx_done_q && !rd_data) |=> ovr_q);
  // R9: reading the buffer with no frame ending drops receive-complete
  assert_rx_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !sh_done) |=> !rx_done_q);
  // R8: a data write always leaves the buffer marked full
  assert_tx_full_R8: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> !tx_empty_q);
  // R1: a master frame finishes with the transfer clock back high
  assert_end_high_R1: assert property (@(posedge clk) disable iff (rst)
    (sh_done && ctrl_q.master) |-> sclk_int);
endmodule

// File: tb/csio_port_tb_top.sv
module csio_port_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       sclk_in, sclk_out_a, sclk_out_b, rxd, txd;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  csio_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_in(sclk_in),
    .sclk_out_a(sclk_out_a), .sclk_out_b(sclk_out_b), .rxd(rxd), .txd(txd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] d, input bit inv);
    return inv ? ~d : d;
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic master_frame(input int idx, input logic [7:0] rxb, input int half,
                              output logic [7:0] txs, output int bad, output int other,
                              output bit tmo);
    logic prev, cur;
    int nrise = 0, since = 0, edges = 0;
    bad = 0; other = 0; txs = 8'h00;
    prev = idx ? sclk_out_b : sclk_out_a;
    for (int t = 0; t < 4000 && nrise < 8; t++) begin
      @(negedge clk);
      cur = idx ? sclk_out_b : sclk_out_a;
      since++;
      if ((idx ? sclk_out_a : sclk_out_b) == 1'b0) other++;
      if (cur != prev) begin
        if (edges > 0 && since != half) bad++;
        edges++; since = 0;
        if (!cur) rxd = rxb[nrise];
        else begin txs[nrise] = txd; nrise++; end
      end
      prev = cur;
    end
    tmo = (nrise < 8);
  endtask

  task automatic slave_frame(input logic [7:0] rxb, output logic [7:0] txs, output int low);
    low = 0;
    for (int k = 0; k < 8; k++) begin
      sclk_in = 1'b0; rxd = rxb[k];
      repeat (8) begin @(negedge clk); if (!sclk_out_a || !sclk_out_b) low++; end
      txs[k] = txd; sclk_in = 1'b1;
      repeat (8) begin @(negedge clk); if (!sclk_out_a || !sclk_out_b) low++; end
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd, txs, d, r;
    int bad, other, low, idx, dv;
    bit tmo, inv;
    void'($urandom(32'd4711));
    rst = 1'b1; bus_addr = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
    sclk_in = 1'b1; rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk("R11 pins/txd", {sclk_out_a, sclk_out_b, txd}, 3'b111);
    bus_read(2'd3, rd); chk("R11 status", rd, 8'h01);
    bus_read(2'd1, rd); chk("R11 ctrl", rd, 8'h00);
    bus_read(2'd2, rd); chk("R11 div", rd, 8'h00);

    // R1 R2 R3 R9: basic master frame on pin A
    bus_write(2'd2, 8'd3); bus_write(2'd1, 8'h03);
    bus_write(2'd0, 8'hA5);
    master_frame(0, 8'h3C, 4, txs, bad, other, tmo);
    chk("R1 tx line", txs, 8'hA5); chk("R1 timeout", tmo, 0);
    chk("R2 half period", bad, 0); chk("R3 pin B idle", other, 0);
    bus_read(2'd3, rd); chk("R9 status after frame", rd, 8'h03);
    bus_read(2'd0, rd); chk("R1 rx byte", rd, 8'h3C);
    bus_read(2'd3, rd); chk("R9 cleared by read", rd, 8'h01);

    // R8 R10: queued second byte and overrun, on pin B
    bus_write(2'd1, 8'h05);
    bus_write(2'd0, 8'h11); bus_write(2'd0, 8'h22);
    bus_read(2'd3, rd); chk("R8 second byte queued", rd, 8'h08);
    master_frame(1, 8'h44, 4, txs, bad, other, tmo);
    chk("R8 first frame", txs, 8'h11); chk("R3 pin A idle", other, 0);
    master_frame(1, 8'h99, 4, txs, bad, other, tmo);
    chk("R8 second frame", txs, 8'h22); chk("R8 timeout", tmo, 0);
    bus_read(2'd3, rd); chk("R10 overrun set", rd, 8'h07);
    bus_read(2'd3, rd); chk("R10 overrun cleared", rd, 8'h03);
    bus_read(2'd0, rd); chk("R10 newest data kept", rd, 8'h99);

    // R5: read without continuous mode starts nothing
    bus_read(2'd0, rd);
    low = 0;
    repeat (60) begin @(negedge clk); if (!sclk_out_a || !sclk_out_b) low++; end
    chk("R5 no clock after read", low, 0);
    bus_read(2'd3, rd); chk("R5 idle status", rd, 8'h01);

    // R6: continuous receive rearm
    bus_write(2'd1, 8'h0B);
    bus_write(2'd0, 8'h5A);
    master_frame(0, 8'h81, 4, txs, bad, other, tmo);
    chk("R6 first frame", txs, 8'h5A);
    bus_read(2'd0, rd); chk("R6 rx byte", rd, 8'h81);
    master_frame(0, 8'h7E, 4, txs, bad, other, tmo);
    chk("R6 auto frame started", tmo, 0); chk("R6 auto frame sends ones", txs, 8'hFF);
    bus_write(2'd1, 8'h03);
    bus_read(2'd0, rd); chk("R6 auto frame data", rd, 8'h7E);

    // R7: inversion
    bus_write(2'd1, 8'h13);
    bus_write(2'd0, 8'hC3);
    master_frame(0, 8'hF0, 4, txs, bad, other, tmo);
    chk("R7 tx inverted", txs, 8'h3C);
    bus_read(2'd0, rd); chk("R7 rx inverted", rd, 8'h0F);

    // R3: select code 00 gives no pin output, frame still runs
    bus_write(2'd1, 8'h01); rxd = 1'b1;
    bus_write(2'd0, 8'h00);
    low = 0;
    repeat (120) begin @(negedge clk); if (!sclk_out_a || !sclk_out_b) low++; end
    chk("R3 no pin for code 00", low, 0);
    bus_read(2'd0, rd); chk("R3 frame ran with code 00", rd, 8'hFF);

    // R4: slave mode with and without inversion
    for (int s = 0; s < 2; s++) begin
      bus_write(2'd1, s ? 8'h12 : 8'h02);
      d = $urandom; r = $urandom;
      bus_write(2'd0, d);
      repeat (4) @(negedge clk);
      slave_frame(r, txs, low);
      chk("R4 slave tx", txs, exp_byte(d, s));
      chk("R4 pins high in slave", low, 0);
      bus_read(2'd0, rd); chk("R4 slave rx", rd, exp_byte(r, s));
    end

    // random master frames
    for (int n = 0; n < 16; n++) begin
      d = $urandom; r = $urandom; idx = $urandom_range(0, 1);
      inv = 1'($urandom_range(0, 1)); dv = $urandom_range(2, 5);
      bus_write(2'd2, 8'(dv));
      bus_write(2'd1, 8'((idx ? 5 : 3) + (inv ? 16 : 0)));
      bus_write(2'd0, d);
      master_frame(idx, r, dv + 1, txs, bad, other, tmo);
      chk("R1 random tx", txs, exp_byte(d, inv));
      chk("R2 random period", bad, 0);
      chk("R3 random other pin", other, 0);
      bus_read(2'd0, rd); chk("R7 random rx", rd, exp_byte(r, inv));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule